// File: doc/BRIEF.md
# Multithreaded Thread Selection Unit

This unit decides, in every clock cycle, which of several hardware threads supplies the next instruction to one shared pipeline. Each thread has its own program counter, which the unit holds. The counter advances when that thread is granted a fetch slot and is overwritten when the thread is redirected. The unit sits in front of the fetch stage. It takes per-thread stall flags and redirect targets, and it produces the thread ID, the fetch address, a valid flag and a flush strobe.

Two scheduling modes are chosen at run time with a single input. In interleaved (fine-grained) mode, the grant rotates among the threads every cycle and passes over any thread that is stalled. No dead cycle is needed to move between threads. In switch-on-miss (coarse-grained) mode, one thread keeps the pipeline until it raises a long-latency stall. The unit then flushes the old thread's in-flight work and moves to another ready thread. That thread fetches only after a fixed refill delay, which models the cost of starting up the pipeline again.

The controller is a three-state machine. ST_FINE is interleaved mode. ST_RUN is switch-on-miss mode with a thread fetching. ST_REFILL is the quiet window after a switch. The transitions are:
- ST_FINE to ST_RUN when the mode input selects switch-on-miss.
- ST_RUN to ST_REFILL when the active thread raises a long stall and another thread is ready. This transition raises the flush strobe.
- ST_REFILL to ST_RUN when the refill count runs out.
- ST_RUN or ST_REFILL to ST_FINE when the mode input returns to interleaved.

Top module: `thread_select_unit`

## Requirements
- R1: After reset the unit is in interleaved mode with the rotation pointer at thread 0. Thread i starts with PC = i * PC_STRIDE (default 0x1000). With all threads ready, the first grant goes to thread 0 at PC 0.
- R2: In interleaved mode with every thread ready, the grants follow the order 0,1,2,3,0,... with a new thread in each consecutive cycle. Each grant advances that thread's PC by INSTR_BYTES (default 4), and the new PC is seen at its next grant.
- R3: In interleaved mode, the grant goes to the first ready thread at or after the rotation pointer, in increasing index order with wrap-around. After each grant the pointer moves to the thread after the one granted. A thread is ready when its short stall and its long stall are both low.
- R4: If no thread is ready in interleaved mode, fetch_valid is 0 for that cycle and the rotation pointer keeps its value.
- R5: A thread whose long stall falls in cycle t is not granted in cycle t. It is eligible again from cycle t+1.
- R6: When switch-on-miss mode is entered, the thread at the rotation pointer becomes active. That thread fetches in every cycle in which it is ready. A short stall on it makes fetch_valid 0 without a switch or a flush.
- R7: In switch-on-miss mode, when the active thread's long stall is high and some other thread is ready, flush is high for exactly that one cycle with fetch_valid 0. The new active thread is the first ready thread after the old one, in round-robin order.
- R8: After a flush, fetch_valid stays 0 for exactly REFILL_CYCLES cycles (default 5). In the cycle after that, the new thread fetches from its saved PC if it is ready.
- R9: In switch-on-miss mode, if the active thread has a long stall and no other thread is ready, the unit stays on that thread with fetch_valid 0 and no flush. It resumes that thread once its stall has cleared (see R5).
- R10: When redirect_valid[i] is high in a cycle, thread i's PC becomes its redirect_pc slice in the next cycle. This takes priority over the advance caused by a grant in the same cycle.
- R11: flush is never raised in interleaved mode. When the mode input returns to interleaved, one more cycle follows the switch-on-miss rules. Interleaved grants then resume with the rotation pointer at the last active thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_coarse | input | 1 | 1 selects switch-on-miss scheduling, 0 selects interleaved |
| short_stall | input | NUM_THREADS | Per-thread short stall flag |
| long_stall | input | NUM_THREADS | Per-thread long-latency stall flag |
| redirect_valid | input | NUM_THREADS | Per-thread PC load strobe |
| redirect_pc | input | NUM_THREADS*PC_W | Per-thread redirect targets, thread i in bits [i*PC_W +: PC_W] |
| fetch_valid | output | 1 | A fetch is issued this cycle |
| fetch_tid | output | TID_W | Selected thread |
| fetch_pc | output | PC_W | PC of the selected thread |
| flush | output | 1 | One-cycle pulse that drains the old thread on a switch |

## Verification
The bench holds every one of the sixteen short-stall masks for several cycles in interleaved mode. A picker with an off-by-one start point, or a pointer that advances from the pointer instead of from the grant, would grant the wrong thread under some mask. The all-stalled mask is followed by an all-ready cycle, which would show a pointer that drifts while idle. The long-stall release is arranged so that the released thread is the only candidate, so granting one cycle early is visible. In switch-on-miss mode the bench counts the quiet refill window to the exact cycle. It also checks both a switch that lands on a thread two positions away and the wait that occurs when no other thread is ready. A design that flushes with nowhere to go, or that miscounts the window, fails there.

// File: rtl/tsu_pkg.sv
package tsu_pkg;

    typedef enum logic [1:0] {
        ST_FINE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_REFILL = 2'd2
    } tsu_state_e;

    function automatic int wrap_inc(input int v, input int n);
        return (v >= n - 1) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/tsu_rr_pick.sv
module tsu_rr_pick #(
    parameter int N     = 4,
    parameter int TID_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    input  logic [TID_W-1:0] base,
    output logic             any,
    output logic [TID_W-1:0] grant
);

    always_comb begin
        int idx;
        any   = |req;
        grant = '0;
        for (int k = N - 1; k >= 0; k--) begin
            idx = (int'(base) + k) % N;
            if (req[idx]) grant = TID_W'(idx);
        end
    end

endmodule

// File: rtl/tsu_pc_bank.sv
module tsu_pc_bank #(
    parameter int N           = 4,
    parameter int PC_W        = 32,
    parameter int TID_W       = $clog2(N),
    parameter int PC_STRIDE   = 4096,
    parameter int INSTR_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_valid,
    input  logic [TID_W-1:0]  adv_tid,
    input  logic [N-1:0]      redirect_valid,
    input  logic [N*PC_W-1:0] redirect_pc,
    input  logic [TID_W-1:0]  rd_tid,
    output logic [PC_W-1:0]   rd_pc
);

    logic [PC_W-1:0] pc_q [N];

    for (genvar i = 0; i < N; i++) begin : g_ctx
        localparam int unsigned RST_PC = i * PC_STRIDE;
        logic advance;
        assign advance = adv_valid && (adv_tid == TID_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pc_q[i] <= PC_W'(RST_PC);
            end else if (redirect_valid[i]) begin
                pc_q[i] <= redirect_pc[i*PC_W +: PC_W];
            end else if (advance) begin
                pc_q[i] <= pc_q[i] + PC_W'(INSTR_BYTES);
            end
        end
    end

    assign rd_pc = pc_q[rd_tid];

endmodule

// File: rtl/tsu_ctrl.sv
module tsu_ctrl
    import tsu_pkg::*;
#(
    parameter int N             = 4,
    parameter int TID_W         = $clog2(N),
    parameter int REFILL_CYCLES = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_coarse,
    input  logic [N-1:0]     short_stall,
    input  logic [N-1:0]     long_stall,
    output logic             fetch_valid,
    output logic [TID_W-1:0] fetch_tid,
    output logic             flush
);

    localparam int CNT_W = $clog2(REFILL_CYCLES + 1);

    tsu_state_e       state_q, state_d;
    logic [TID_W-1:0] cur_q, cur_d;
    logic [TID_W-1:0] rr_q, rr_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [N-1:0]     long_q;

    logic [N-1:0]     ready;
    logic [N-1:0]     alt_req;
    logic [TID_W-1:0] alt_base;
    logic             fine_any, alt_any;
    logic [TID_W-1:0] fine_grant, alt_grant;
    logic             sw_now;

    assign ready    = ~short_stall & ~long_stall & ~long_q;
    assign alt_req  = ready & ~(N'(1) << cur_q);
    assign alt_base = TID_W'(wrap_inc(int'(cur_q), N));

    tsu_rr_pick #(.N(N), .TID_W(TID_W)) u_fine_pick (
        .req   (ready),
        .base  (rr_q),
        .any   (fine_any),
        .grant (fine_grant)
    );

    tsu_rr_pick #(.N(N), .TID_W(TID_W)) u_alt_pick (
        .req   (alt_req),
        .base  (alt_base),
        .any   (alt_any),
        .grant (alt_grant)
    );

    assign sw_now = (state_q == ST_RUN) && long_stall[cur_q] && alt_any;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FINE;
            cur_q   <= '0;
            rr_q    <= '0;
            cnt_q   <= '0;
            long_q  <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            rr_q    <= rr_d;
            cnt_q   <= cnt_d;
            long_q  <= long_stall;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        rr_d    = rr_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_FINE: begin
                if (fine_any) rr_d = TID_W'(wrap_inc(int'(fine_grant), N));
                if (mode_coarse) begin
                    state_d = ST_RUN;
                    cur_d   = rr_d;
                end
            end
            ST_RUN: begin
                if (sw_now) begin
                    state_d = ST_REFILL;
                    cur_d   = alt_grant;
                    cnt_d   = CNT_W'(REFILL_CYCLES);
                end
                if (!mode_coarse) begin
                    state_d = ST_FINE;
                    rr_d    = sw_now ? alt_grant : cur_q;
                end
            end
            ST_REFILL: begin
                if (cnt_q <= CNT_W'(1)) state_d = ST_RUN;
                else                    cnt_d   = cnt_q - CNT_W'(1);
                if (!mode_coarse) begin
                    state_d = ST_FINE;
                    rr_d    = cur_q;
                end
            end
            default: state_d = ST_FINE;
        endcase
    end

    // outputs
    always_comb begin
        fetch_valid = 1'b0;
        fetch_tid   = cur_q;
        flush       = 1'b0;
        unique case (state_q)
            ST_FINE: begin
                fetch_valid = fine_any;
                fetch_tid   = fine_grant;
            end
            ST_RUN: begin
                fetch_valid = ready[cur_q];
                flush       = sw_now;
            end
            ST_REFILL: begin
                fetch_valid = 1'b0;
            end
            default: fetch_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/thread_select_unit.sv
module thread_select_unit #(
    parameter int NUM_THREADS   = 4,
    parameter int PC_W          = 32,
    parameter int PC_STRIDE     = 4096,
    parameter int INSTR_BYTES   = 4,
    parameter int REFILL_CYCLES = 5,
    localparam int TID_W        = $clog2(NUM_THREADS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        mode_coarse,
    input  logic [NUM_THREADS-1:0]      short_stall,
    input  logic [NUM_THREADS-1:0]      long_stall,
    input  logic [NUM_THREADS-1:0]      redirect_valid,
    input  logic [NUM_THREADS*PC_W-1:0] redirect_pc,
    output logic                        fetch_valid,
    output logic [TID_W-1:0]            fetch_tid,
    output logic [PC_W-1:0]             fetch_pc,
    output logic                        flush
);

    tsu_ctrl #(
        .N             (NUM_THREADS),
        .TID_W         (TID_W),
        .REFILL_CYCLES (REFILL_CYCLES)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_coarse (mode_coarse),
        .short_stall (short_stall),
        .long_stall  (long_stall),
        .fetch_valid (fetch_valid),
        .fetch_tid   (fetch_tid),
        .flush       (flush)
    );

    tsu_pc_bank #(
        .N           (NUM_THREADS),
        .PC_W        (PC_W),
        .TID_W       (TID_W),
        .PC_STRIDE   (PC_STRIDE),
        .INSTR_BYTES (INSTR_BYTES)
    ) u_pcs (
        .clk            (clk),
        .rst_n          (rst_n),
        .adv_valid      (fetch_valid),
        .adv_tid        (fetch_tid),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .rd_tid         (fetch_tid),
        .rd_pc          (fetch_pc)
    );

endmodule

// File: rtl/tsu_checker.sv
module tsu_checker #(
    parameter int N     = 4,
    parameter int TID_W = $clog2(N)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_coarse,
    input logic [N-1:0]     short_stall,
    input logic [N-1:0]     long_stall,
    input logic             fetch_valid,
    input logic [TID_W-1:0] fetch_tid,
    input logic             flush
);

    logic [N-1:0] long_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) long_prev <= '0;
        else        long_prev <= long_stall;
    end

    a_r3_grant_is_ready: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> (!short_stall[fetch_tid] && !long_stall[fetch_tid]));

    a_r5_long_clear_delay: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> !long_prev[fetch_tid]);

    a_r7_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);

    a_r7_flush_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !fetch_valid);

    a_r8_quiet_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !fetch_valid);

    a_r9_flush_needs_long: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> long_stall[fetch_tid]);

    a_r11_flush_coarse_only: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> $past(mode_coarse));

endmodule

bind thread_select_unit tsu_checker #(
    .N     (NUM_THREADS),
    .TID_W (TID_W)
) u_tsu_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_coarse (mode_coarse),
    .short_stall (short_stall),
    .long_stall  (long_stall),
    .fetch_valid (fetch_valid),
    .fetch_tid   (fetch_tid),
    .flush       (flush)
);

// File: tb/tb_thread_select_unit.sv
module tb_thread_select_unit;

    localparam int NT     = 4;
    localparam int PCW    = 32;
    localparam int STRIDE = 4096;
    localparam int STEP   = 4;
    localparam int REFILL = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            mode_coarse = 1'b0;
    logic [NT-1:0]   short_stall = '0;
    logic [NT-1:0]   long_stall = '0;
    logic [NT-1:0]   redirect_valid = '0;
    logic [NT*PCW-1:0] redirect_pc = '0;
    logic            fetch_valid;
    logic [1:0]      fetch_tid;
    logic [PCW-1:0]  fetch_pc;
    logic            flush;

    int n_checks = 0;
    int n_fail   = 0;

    int            m_ptr;
    logic [PCW-1:0] m_pc [NT];
    logic [NT-1:0] m_prev_ls;

    always #5 clk = ~clk;

    thread_select_unit #(
        .NUM_THREADS   (NT),
        .PC_W          (PCW),
        .PC_STRIDE     (STRIDE),
        .INSTR_BYTES   (STEP),
        .REFILL_CYCLES (REFILL)
    ) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_coarse    (mode_coarse),
        .short_stall    (short_stall),
        .long_stall     (long_stall),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .fetch_valid    (fetch_valid),
        .fetch_tid      (fetch_tid),
        .fetch_pc       (fetch_pc),
        .flush          (flush)
    );

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(10 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int pick(input logic [NT-1:0] req, input int base);
        for (int k = 0; k < NT; k++) begin
            if (req[(base + k) % NT]) return (base + k) % NT;
        end
        return -1;
    endfunction

    function automatic logic [NT-1:0] ready_now();
        return ~short_stall & ~long_stall & ~m_prev_ls;
    endfunction

    task automatic tick(input bit ev, input int et, input bit ef, input string req);
        #1;
        check(req, "flush", 64'(flush), 64'(ef));
        check(req, "fetch_valid", 64'(fetch_valid), 64'(ev));
        if (ev) begin
            check(req, "fetch_tid", 64'(fetch_tid), 64'(et));
            check(req, "fetch_pc", 64'(fetch_pc), 64'(m_pc[et]));
        end
        for (int i = 0; i < NT; i++) begin
            if (redirect_valid[i])     m_pc[i] = redirect_pc[i*PCW +: PCW];
            else if (ev && et == i)    m_pc[i] = m_pc[i] + PCW'(STEP);
        end
        m_prev_ls = long_stall;
        @(negedge clk);
    endtask

    task automatic fine_tick(input string req);
        int g;
        g = pick(ready_now(), m_ptr);
        tick(g >= 0, g, 1'b0, req);
        if (g >= 0) m_ptr = (g + 1) % NT;
    endtask

    initial begin
        int c;
        int nx;
        m_ptr = 0;
        m_prev_ls = '0;
        for (int i = 0; i < NT; i++) m_pc[i] = PCW'(i * STRIDE);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: first grants after reset
        for (int i = 0; i < 4; i++) fine_tick("R1");
        // R2: full rotation with all threads ready
        for (int i = 0; i < 8; i++) fine_tick("R2");

        // R3 / R4: every short-stall mask
        for (int mask = 0; mask < 16; mask++) begin
            short_stall = 4'(mask);
            for (int k = 0; k < 5; k++) fine_tick(mask == 15 ? "R4" : "R3");
        end
        short_stall = '0;
        fine_tick("R4");
        fine_tick("R4");

        // R5: long stall release on thread 2
        long_stall = 4'b0100;
        for (int k = 0; k < 3; k++) fine_tick("R5");
        long_stall = '0;
        short_stall = 4'b1011;
        fine_tick("R5");
        fine_tick("R5");
        short_stall = '0;
        fine_tick("R5");

        // R10: redirects, including on the granted thread
        for (int i = 0; i < NT; i++) begin
            redirect_valid = 4'(1 << i);
            redirect_pc[i*PCW +: PCW] = 32'hA000_0000 + PCW'(i * 32'h100);
            fine_tick("R10");
        end
        redirect_valid = '0;
        for (int k = 0; k < 8; k++) fine_tick("R10");

        // R6: enter switch-on-miss mode
        mode_coarse = 1'b1;
        fine_tick("R6");
        c = m_ptr;
        for (int k = 0; k < 3; k++) tick(1'b1, c, 1'b0, "R6");
        short_stall = 4'(1 << c);
        tick(1'b0, c, 1'b0, "R6");
        tick(1'b0, c, 1'b0, "R6");
        short_stall = '0;
        tick(1'b1, c, 1'b0, "R6");

        // R7 / R8: switch on long stall, then refill window
        long_stall = 4'(1 << c);
        nx = pick(ready_now() & ~4'(1 << c), (c + 1) % NT);
        tick(1'b0, c, 1'b1, "R7");
        c = nx;
        for (int k = 0; k < REFILL; k++) tick(1'b0, c, 1'b0, "R8");
        tick(1'b1, c, 1'b0, "R8");
        long_stall = '0;
        tick(1'b1, c, 1'b0, "R8");

        // R9: long stall with no alternative
        long_stall = 4'(1 << c);
        short_stall = ~4'(1 << c);
        for (int k = 0; k < 3; k++) tick(1'b0, c, 1'b0, "R9");
        long_stall = '0;
        tick(1'b0, c, 1'b0, "R9");
        tick(1'b1, c, 1'b0, "R9");

        // R7: switch to the only ready thread two places away
        nx = (c + 2) % NT;
        long_stall = 4'(1 << c);
        short_stall = ~(4'(1 << c) | 4'(1 << nx));
        tick(1'b0, c, 1'b1, "R7");
        c = nx;
        long_stall = '0;
        short_stall = '0;
        for (int k = 0; k < REFILL; k++) tick(1'b0, c, 1'b0, "R8");
        tick(1'b1, c, 1'b0, "R8");

        // R11: return to interleaved mode
        mode_coarse = 1'b0;
        tick(1'b1, c, 1'b0, "R11");
        m_ptr = c;
        for (int k = 0; k < 6; k++) fine_tick("R11");
        long_stall = 4'b0001;
        for (int k = 0; k < 3; k++) fine_tick("R11");
        long_stall = '0;
        for (int k = 0; k < 3; k++) fine_tick("R11");

        finish_run();
    end

endmodule